// File: doc/BRIEF.md
# Automatic Diode-Emulation Mode Selector

This block sits beside the PWM logic of a synchronous buck converter and decides, once per switching period, whether the low-side switch behaves as a full synchronous rectifier (forced-continuous conduction) or shuts off when the inductor current reverses (diode emulation). Its only time base is a one-clock strobe from the PWM generator. On that strobe it samples a phase-polarity bit taken during low-side conduction. A high sample means the switch node sat above ground, which is the sign of reverse inductor current at light load.

A run of consecutive high samples, `RUN_LEN` long (eight by default), arms diode emulation. The mode changes at the next strobe. One low sample disarms it, and the mode falls back at the strobe after. A lock input held high pins the converter in forced-continuous mode and wipes the run count.

The low-side enable output is always asserted in forced-continuous mode. In diode emulation it follows a zero-cross comparator bit, so the switch turns off while current flows backwards.

Top module: `dem_mode_selector`

## Requirements
- R1: After synchronous reset, `dem_active` is 0, `ls_enable` is 1 and the run count is zero, so `RUN_LEN` fresh high samples are needed before diode emulation can begin.
- R2: While `force_ccm` is 1 at a strobe, `dem_active` is 0 after that strobe, whatever `phase_high` shows.
- R3: While `dem_active` is 0, `ls_enable` is 1 for either value of `zc_reverse`.
- R4: When strobes k-7..k all sample `phase_high`=1 with `force_ccm`=0, `dem_active` is still 0 after strobe k and becomes 1 at the clock edge of strobe k+1, regardless of the sample taken at k+1.
- R5: A strobe sampling `phase_high`=0 while `dem_active`=1 leaves `dem_active` at 1 after that strobe, and `dem_active` becomes 0 at the edge of the next strobe.
- R6: While `dem_active` is 1, `ls_enable` equals the inverse of `zc_reverse` (`zc_reverse`=1 means reverse inductor current), with no clock delay.
- R7: A strobe sampling `phase_high`=0 before the run is complete resets the run count to zero, so a later entry needs `RUN_LEN` new consecutive high samples.
- R8: A strobe with `force_ccm`=1 while in diode emulation sets `dem_active` to 0 at that edge and clears the run count. After `force_ccm` returns to 0, `RUN_LEN` new high samples are needed to enter again.
- R9: `phase_high` is sampled only on clock edges where `pulse_stb` is 1. Its value on any other cycle has no effect on the count or the mode.
- R10: `dem_active` changes only on clock edges where `pulse_stb` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_stb | input | 1 | One-cycle strobe per PWM pulse from the PWM logic |
| phase_high | input | 1 | Phase polarity sampled during low-side conduction; 1 = above ground |
| force_ccm | input | 1 | 1 forbids diode emulation; 0 permits automatic selection |
| zc_reverse | input | 1 | Zero-cross comparator; 1 = inductor current flowing in reverse |
| dem_active | output | 1 | 1 while the converter runs in diode emulation |
| ls_enable | output | 1 | Low-side gate enable after polarity qualification |

## Verification
Entry is tried with an unbroken run of high samples. Each intermediate strobe is checked, which separates a design that enters one pulse early or late from a correct one. A run broken by a single low sample after seven highs shows whether the count truly restarts, as opposed to pausing or merely decrementing. Sample values held between strobes show whether sampling is strobe-only. The lock is toggled while in diode emulation, and the post-lock entry is then counted, which tells an immediate fall-back with a cleared count apart from one that leaves a stale count behind. The zero-cross input is swept in both modes to separate the mode-dependent gating.

// File: rtl/dem_sel_pkg.sv
package dem_sel_pkg;

    typedef enum logic {
        MODE_FCCM = 1'b0,
        MODE_DEM  = 1'b1
    } conv_mode_e;

    // One sampled PWM pulse event
    typedef struct packed {
        logic take;        // strobe present this cycle
        logic phase_high;  // phase node above ground during low-side conduction
        logic lock;        // forced-continuous request
    } pulse_evt_t;

    // Saturating run-length increment
    function automatic int unsigned next_run(input int unsigned cur,
                                             input int unsigned lim);
        return (cur >= lim) ? lim : cur + 1;
    endfunction

endpackage

// File: rtl/dem_run_counter.sv
module dem_run_counter
    import dem_sel_pkg::*;
#(
    parameter int unsigned RUN_LEN = 8,
    parameter int unsigned CNT_W   = $clog2(RUN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  pulse_evt_t       evt,
    output logic [CNT_W-1:0] run_cnt,
    output logic             run_met
);

    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = CNT_W'(next_run(int'(run_cnt), RUN_LEN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            run_met <= 1'b0;
        end else if (evt.take) begin
            if (evt.lock || !evt.phase_high) begin
                run_cnt <= '0;
                run_met <= 1'b0;
            end else begin
                run_cnt <= cnt_inc;
                run_met <= (int'(cnt_inc) == int'(RUN_LEN));
            end
        end
    end

endmodule

// File: rtl/dem_mode_ctrl.sv
module dem_mode_ctrl
    import dem_sel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pulse_evt_t evt,
    input  logic       run_met,
    output conv_mode_e mode
);

    // The decision armed by earlier pulses is applied at this pulse boundary.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_FCCM;
        end else if (evt.take) begin
            if (evt.lock)
                mode <= MODE_FCCM;
            else
                mode <= run_met ? MODE_DEM : MODE_FCCM;
        end
    end

endmodule

// File: rtl/dem_gate_qual.sv
module dem_gate_qual
    import dem_sel_pkg::*;
(
    input  conv_mode_e mode,
    input  logic       zc_reverse,
    output logic       ls_en
);

    always_comb begin
        ls_en = (mode == MODE_FCCM) || !zc_reverse;
    end

endmodule

// File: rtl/dem_mode_selector.sv
module dem_mode_selector
    import dem_sel_pkg::*;
#(
    parameter int unsigned RUN_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_stb,
    input  logic phase_high,
    input  logic force_ccm,
    input  logic zc_reverse,
    output logic dem_active,
    output logic ls_enable
);

    localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);

    pulse_evt_t       evt;
    logic [CNT_W-1:0] run_cnt;
    logic             run_met;
    conv_mode_e       mode;

    always_comb begin
        evt.take       = pulse_stb;
        evt.phase_high = phase_high;
        evt.lock       = force_ccm;
    end

    dem_run_counter #(
        .RUN_LEN(RUN_LEN),
        .CNT_W  (CNT_W)
    ) u_run (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .run_cnt(run_cnt),
        .run_met(run_met)
    );

    dem_mode_ctrl u_mode (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .run_met(run_met),
        .mode   (mode)
    );

    dem_gate_qual u_gate (
        .mode      (mode),
        .zc_reverse(zc_reverse),
        .ls_en     (ls_enable)
    );

    always_comb begin
        dem_active = (mode == MODE_DEM);
    end

endmodule

// File: rtl/dem_mode_selector_chk.sv
module dem_mode_selector_chk #(
    parameter int unsigned RUN_LEN = 8,
    parameter int unsigned CNT_W   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             pulse_stb,
    input logic             phase_high,
    input logic             force_ccm,
    input logic             zc_reverse,
    input logic             dem_active,
    input logic             ls_enable,
    input logic [CNT_W-1:0] run_cnt,
    input logic             run_met
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!dem_active && run_cnt == '0 && !run_met));

    assert_lock_fccm_R2: assert property (@(posedge clk) disable iff (rst)
        (pulse_stb && force_ccm) |=> !dem_active);

    assert_fccm_gate_R3: assert property (@(posedge clk) disable iff (rst)
        !dem_active |-> ls_enable);

    assert_run_arms_R4: assert property (@(posedge clk) disable iff (rst)
        (pulse_stb && !force_ccm && phase_high && run_cnt == CNT_W'(RUN_LEN - 1)) |=> run_met);

    assert_armed_enters_R4: assert property (@(posedge clk) disable iff (rst)
        (pulse_stb && !force_ccm && run_met) |=> dem_active);

    assert_disarmed_exits_R5: assert property (@(posedge clk) disable iff (rst)
        (pulse_stb && dem_active && !run_met) |=> !dem_active);

    assert_dem_gate_R6: assert property (@(posedge clk) disable iff (rst)
        dem_active |-> (ls_enable == !zc_reverse));

    assert_low_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (pulse_stb && !phase_high) |=> (run_cnt == '0 && !run_met));

    assert_lock_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (pulse_stb && force_ccm) |=> (run_cnt == '0 && !run_met));

    assert_idle_count_R9: assert property (@(posedge clk) disable iff (rst)
        !pulse_stb |=> $stable(run_cnt));

    assert_mode_on_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        !pulse_stb |=> $stable(dem_active));

endmodule

bind dem_mode_selector dem_mode_selector_chk #(
    .RUN_LEN(RUN_LEN),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pulse_stb (pulse_stb),
    .phase_high(phase_high),
    .force_ccm (force_ccm),
    .zc_reverse(zc_reverse),
    .dem_active(dem_active),
    .ls_enable (ls_enable),
    .run_cnt   (run_cnt),
    .run_met   (run_met)
);

// File: tb/dem_mode_selector_bench.sv
module dem_mode_selector_bench;

    localparam int CLK_PERIOD = 10;
    localparam int RUN_LEN    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pulse_stb = 1'b0;
    logic phase_high = 1'b0;
    logic force_ccm = 1'b0;
    logic zc_reverse = 1'b0;
    logic dem_active;
    logic ls_enable;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dem_mode_selector #(.RUN_LEN(RUN_LEN)) u_dem_mode_selector (
        .clk       (clk),
        .rst       (rst),
        .pulse_stb (pulse_stb),
        .phase_high(phase_high),
        .force_ccm (force_ccm),
        .zc_reverse(zc_reverse),
        .dem_active(dem_active),
        .ls_enable (ls_enable)
    );

    task automatic check(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pulse_stb = 1'b0; force_ccm = 1'b0; phase_high = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // One PWM pulse: strobe for one cycle with the given sample, then two idle cycles.
    task automatic pulse(input logic ph);
        @(negedge clk);
        pulse_stb = 1'b1; phase_high = ph;
        @(negedge clk);
        pulse_stb = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check(dem_active, 1'b0, "R1 dem_active after reset");
        zc_reverse = 1'b1; #1;
        check(ls_enable, 1'b1, "R1/R3 ls_enable after reset with reverse current");
        // count zero: RUN_LEN-1 highs must not arm
        for (int i = 0; i < RUN_LEN - 1; i++) pulse(1'b1);
        pulse(1'b0);
        check(dem_active, 1'b0, "R1 no entry from a short run after reset");
        zc_reverse = 1'b0;
    endtask

    task automatic t_entry();
        do_reset();
        for (int i = 0; i < RUN_LEN; i++) begin
            pulse(1'b1);
            check(dem_active, 1'b0, $sformatf("R4 still continuous after high %0d", i + 1));
        end
        pulse(1'b0);
        check(dem_active, 1'b1, "R4 entry on strobe after the run");
    endtask

    task automatic t_gate();
        do_reset();
        for (int i = 0; i <= RUN_LEN; i++) pulse(1'b1);
        check(dem_active, 1'b1, "R6 setup in diode emulation");
        zc_reverse = 1'b1; #1;
        check(ls_enable, 1'b0, "R6 reverse current blocks low side");
        zc_reverse = 1'b0; #1;
        check(ls_enable, 1'b1, "R6 forward current enables low side");
        zc_reverse = 1'b1; #1;
        check(ls_enable, 1'b0, "R6 reverse again blocks low side");
        zc_reverse = 1'b0;
    endtask

    task automatic t_exit();
        do_reset();
        for (int i = 0; i <= RUN_LEN; i++) pulse(1'b1);
        // low sample held between strobes must do nothing
        phase_high = 1'b0;
        repeat (10) @(negedge clk);
        check(dem_active, 1'b1, "R9/R10 low between strobes ignored");
        pulse(1'b0);
        check(dem_active, 1'b1, "R5 still in DEM on the low-sample strobe");
        pulse(1'b1);
        check(dem_active, 1'b0, "R5 exit on the following strobe");
        zc_reverse = 1'b1; #1;
        check(ls_enable, 1'b1, "R3 continuous mode ignores reverse current");
        zc_reverse = 1'b0;
    endtask

    task automatic t_run_clear();
        do_reset();
        for (int i = 0; i < RUN_LEN - 1; i++) pulse(1'b1);
        pulse(1'b0);
        for (int i = 0; i < RUN_LEN - 1; i++) pulse(1'b1);
        check(dem_active, 1'b0, "R7 broken run does not arm");
        pulse(1'b1);
        check(dem_active, 1'b0, "R7 full fresh run not yet applied");
        pulse(1'b1);
        check(dem_active, 1'b1, "R7 entry after full fresh run");
    endtask

    task automatic t_lock();
        do_reset();
        for (int i = 0; i <= RUN_LEN; i++) pulse(1'b1);
        check(dem_active, 1'b1, "R8 setup in diode emulation");
        @(negedge clk);
        force_ccm = 1'b1;
        repeat (5) @(negedge clk);
        check(dem_active, 1'b1, "R10 lock waits for pulse boundary");
        pulse(1'b1);
        check(dem_active, 1'b0, "R8 lock forces continuous at strobe");
        for (int i = 0; i < RUN_LEN + 2; i++) pulse(1'b1);
        check(dem_active, 1'b0, "R2 lock held with many high samples");
        force_ccm = 1'b0;
        for (int i = 0; i < RUN_LEN - 1; i++) pulse(1'b1);
        check(dem_active, 1'b0, "R8 count cleared by lock");
        pulse(1'b1);
        pulse(1'b1);
        check(dem_active, 1'b1, "R8 re-entry after fresh run");
    endtask

    task automatic t_strobe_only();
        do_reset();
        phase_high = 1'b1;
        repeat (40) @(negedge clk);
        check(dem_active, 1'b0, "R9 high without strobes does not enter");
        for (int i = 0; i < RUN_LEN - 1; i++) pulse(1'b1);
        phase_high = 1'b1;
        repeat (20) @(negedge clk);
        pulse(1'b1);
        check(dem_active, 1'b0, "R9 idle highs not counted");
        pulse(1'b1);
        check(dem_active, 1'b1, "R9 entry after exactly RUN_LEN strobes");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_entry();
        t_gate();
        t_exit();
        t_run_clear();
        t_lock();
        t_strobe_only();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule